// File: doc/BRIEF.md
# Programmable Clock Prescale Scaler

This block divides a periodic one-cycle input enable by a programmable even ratio. The result is a slower clock source for pulse-width modulation channels. All logic runs on one bus clock. An 8-bit scale value is held in a register that a simple write strobe loads. A down counter steps once per input enable and emits a pulse each time it passes through one. That pulse train drives a toggle flop, so the overall ratio is twice the scale value. A scale of zero stands for 256.

Two outputs are provided. The first is a square-wave scaled clock. The second is a one-bus-cycle enable that marks each rising edge of that square wave, for logic that runs on the bus clock with an enable. Every write to the scale register reloads the counter at once. This holds even when the new value equals the old one, so a rate change takes effect without first counting out the old period.

Top module: `prescale_scaler`

## Requirements
- R1: After reset, scaled_clk_o and scaled_en_o are 0, the scale value is 0 (meaning 256), and the counter holds 256.
- R2: The counter changes only on a bus cycle with tick_i high. While tick_i stays low, scaled_clk_o does not change.
- R3: When tick_i is high and the counter holds 1, a division pulse is produced and the counter reloads from the scale register in that same cycle. Otherwise tick_i decrements the counter.
- R4: Each division pulse inverts scaled_clk_o. One full scaled_clk_o period therefore spans 2 x scale ticks, for scale values 1 to 255.
- R5: A scale value of 0x00 gives a counter length of 256, so the period is 512 ticks.
- R6: A cycle with wr_en_i high stores wr_data_i and loads the counter with it (0 loaded as 256) on that edge. This applies even when the value is unchanged, so the next period starts at the new rate at once.
- R7: When wr_en_i and tick_i are high in the same cycle, the write reload takes effect, the counter does not decrement, and scaled_clk_o does not change.
- R8: scaled_en_o is high for exactly one bus cycle, in the first cycle in which scaled_clk_o is 1 after being 0.
- R9: With tick_i every 4 bus cycles, scale 0xFF gives 2040 bus cycles between scaled_en_o pulses and scale 0x01 gives 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Input rate enable, one cycle per tick |
| wr_en_i | input | 1 | Scale register write strobe |
| wr_data_i | input | SCALE_W | Scale value to write (0 means 2^SCALE_W) |
| scaled_clk_o | output | 1 | Divided square-wave clock |
| scaled_en_o | output | 1 | One-cycle pulse on each rising edge of scaled_clk_o |

## Verification
The bench builds the block with the default SCALE_W of 8. At that width the full-scale case (zero treated as 256) takes about 2048 bus cycles per period, which is short enough to measure several periods directly. The bench generates tick_i every fourth bus cycle, so the 2040-cycle and 8-cycle periods can be checked against exact values. It can also stop the ticks and pulse tick_i by hand, which puts a write and a tick in the same cycle and shows how the counter steps one tick at a time.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/prescale_scale_reg.sv
module prescale_scale_reg #(
  parameter int SCALE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [SCALE_W-1:0] wr_data_i,
  output logic [SCALE_W-1:0] scale_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      scale_o <= '0;
    else if (wr_en_i) scale_o <= wr_data_i;
  end
endmodule

// File: rtl/prescale_counter.sv
module prescale_counter #(
  parameter int SCALE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [SCALE_W-1:0] load_val_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic             pulse_o,
  output logic [SCALE_W:0] count_o
);
  localparam int CW = SCALE_W + 1;
  localparam logic [CW-1:0] FULL = {1'b1, {SCALE_W{1'b0}}};
  localparam logic [CW-1:0] ONE  = CW'(1);

  // zero encodes the full range
  function automatic logic [CW-1:0] eff_len(input logic [SCALE_W-1:0] v);
    return (v == '0) ? FULL : {1'b0, v};
  endfunction

  logic [CW-1:0] cnt_q;

  assign pulse_o = tick_i && !load_i && (cnt_q == ONE);
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= FULL;
    else if (load_i)  cnt_q <= eff_len(load_val_i);
    else if (pulse_o) cnt_q <= eff_len(scale_i);
    else if (tick_i)  cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/prescale_half_div.sv
module prescale_half_div
  import prescale_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic clk_o,
  output logic rise_o
);
  phase_e ph_q;
  logic   rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_LOW;
      rise_q <= 1'b0;
    end else begin
      rise_q <= pulse_i && (ph_q == PH_LOW);
      if (pulse_i) ph_q <= (ph_q == PH_LOW) ? PH_HIGH : PH_LOW;
    end
  end

  assign clk_o  = (ph_q == PH_HIGH);
  assign rise_o = rise_q;
endmodule

// File: rtl/prescale_scaler.sv
module prescale_scaler #(
  parameter int SCALE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic [SCALE_W-1:0] wr_data_i,
  output logic               scaled_clk_o,
  output logic               scaled_en_o
);
  logic [SCALE_W-1:0] scale_w;
  logic [SCALE_W:0]   count_w;
  logic               pulse_w;

  prescale_scale_reg #(.SCALE_W(SCALE_W)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .scale_o(scale_w)
  );

  prescale_counter #(.SCALE_W(SCALE_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .load_i(wr_en_i),
    .load_val_i(wr_data_i), .scale_i(scale_w), .pulse_o(pulse_w),
    .count_o(count_w)
  );

  prescale_half_div u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(pulse_w),
    .clk_o(scaled_clk_o), .rise_o(scaled_en_o)
  );
endmodule

// File: rtl/prescale_scaler_chk.sv
module prescale_scaler_chk #(
  parameter int SCALE_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               wr_en_i,
  input logic [SCALE_W-1:0] wr_data_i,
  input logic               scaled_clk_o,
  input logic               scaled_en_o,
  input logic [SCALE_W:0]   count_i
);
  localparam logic [SCALE_W:0] FULL = {1'b1, {SCALE_W{1'b0}}};

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(scaled_clk_o)); // R2

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i != '0) && (count_i <= FULL)); // R3

  AST_WR_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (count_i == (($past(wr_data_i) == '0) ? FULL
                                : {1'b0, $past(wr_data_i)}))); // R6

  AST_WR_NO_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> $stable(scaled_clk_o)); // R7

  AST_EN_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scaled_en_o |-> (scaled_clk_o && !$past(scaled_clk_o))); // R8

  AST_EN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scaled_en_o |=> !scaled_en_o); // R8
endmodule

bind prescale_scaler prescale_scaler_chk #(.SCALE_W(SCALE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .scaled_clk_o(scaled_clk_o),
  .scaled_en_o(scaled_en_o), .count_i(count_w)
);

// File: tb/sim_prescale_scaler.sv
`timescale 1ns/1ps
module sim_prescale_scaler;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, auto_tick = 1'b0, man_tick = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [1:0] tdiv = '0;
  logic tick, sclk, sen;
  int cyc = 0, checks = 0, errors = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (auto_tick) tdiv <= tdiv + 2'd1; else tdiv <= '0;
  assign tick = (auto_tick && tdiv == 2'd0) || man_tick;

  prescale_scaler #(.SCALE_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .scaled_clk_o(sclk), .scaled_en_o(sen)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [W-1:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_en(output int at);
    at = -1;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (sen) begin at = cyc; break; end
    end
  endtask

  task automatic test_reset();
    int t;
    chk("R1 clk", int'(sclk), 0);
    chk("R1 en", int'(sen), 0);
    auto_tick = 1'b1;
    wait_en(t);
    // 256 ticks to the first toggle, ticks every 4 cycles
    chk("R1 R5 first edge window", int'(t >= 1020 && t <= 1032), 1);
  endtask

  task automatic test_period(input string req, input logic [W-1:0] s, input int exp);
    int t0, t1, t2;
    do_write(s);
    wait_en(t0); wait_en(t1); wait_en(t2);
    chk(req, t2 - t1, exp);
    chk({req, " R8 high at en"}, int'(t1 > 0), 1);
  endtask

  task automatic test_midcount();
    int tw, t1, t2;
    do_write(8'hFF);
    repeat (300) @(negedge clk);
    tw = cyc;
    do_write(8'h02);
    wait_en(t1); wait_en(t2);
    chk("R6 settle fast", int'(t1 > 0 && (t1 - tw) <= 26), 1);
    chk("R6 new period", t2 - t1, 16);
  endtask

  task automatic test_same_value_reload();
    logic s0;
    do_write(8'h03);
    repeat (40) @(negedge clk);
    s0 = sclk;
    // rewrite every 8 cycles: counter never reaches 1
    for (int k = 0; k < 25; k++) begin
      do_write(8'h03);
      repeat (6) @(negedge clk);
    end
    chk("R6 same value reload", int'(sclk), int'(s0));
  endtask

  task automatic test_collision();
    logic s0;
    auto_tick = 1'b0;
    repeat (4) @(negedge clk);
    do_write(8'h01);
    s0 = sclk;
    repeat (20) @(negedge clk);
    chk("R2 hold without tick", int'(sclk), int'(s0));
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h02; man_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; man_tick = 1'b0;
    chk("R7 write wins", int'(sclk), int'(s0));
    @(negedge clk); man_tick = 1'b1;
    @(negedge clk); man_tick = 1'b0;
    chk("R3 decrement no pulse", int'(sclk), int'(s0));
    @(negedge clk); man_tick = 1'b1;
    @(negedge clk); man_tick = 1'b0;
    chk("R3 R4 pulse toggles", int'(sclk), int'(!s0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_period("R9 R4 scale 01", 8'h01, 8);
    test_period("R4 scale 02", 8'h02, 16);
    test_period("R9 scale FF", 8'hFF, 2040);
    test_period("R5 scale 00", 8'h00, 2048);
    test_midcount();
    test_same_value_reload();
    test_collision();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule